// File: doc/BRIEF.md
# Receive Special-Character Filter

This block sits between a serial receiver's deserializer and the receive storage. Each received character arrives with a valid strobe and its error flags. The block optionally clears bit 7 and compares the result with a programmable match character. It honours a programmable escape character that exempts the following character from matching. It also reports the start of a line break and, when enabled, the end of that break. Each result is held in a single output slot until the consumer acknowledges it. No new character is accepted while the slot is full.

An option register sets the behaviour. Bit 7 is strip, bit 6 is escape enable, bit 5 is compare-on-error and bit 2 is end-of-break tracking. Writes to bits 4:3 and 1:0 are discarded. A four-state machine controls the block:
- OPEN: the slot is free and the line is normal.
- HOLD: a result is held while the line is normal.
- WATCH: the slot is free and the block is waiting for the break to end.
- WATCH_HOLD: a result is held while the block is still watching.

The state transitions are:
- OPEN goes to HOLD on an accepted character, or on a break when tracking is off.
- OPEN goes to WATCH_HOLD on a break when tracking is on.
- HOLD goes to OPEN on acknowledge.
- WATCH_HOLD goes to WATCH on acknowledge.
- WATCH goes to HOLD on an accepted non-break character or an idle indication.
- WATCH stays in WATCH on a further break character.

Top module: `rx_char_filter`

## Requirements
- R1: The option register resets to 0x00. A write stores bits 7, 6, 5 and 2. Bits 4:3 and 1:0 always read 0, so writing 0xFF reads back 0xE4.
- R2: With option bit 7 set, bit 7 of each accepted character is cleared. The cleared character appears on out_data and is the value used in every comparison.
- R3: An error-free, unescaped character whose processed value equals match_char gives out_match=1. Any other value gives out_match=0.
- R4: With option bit 5 clear, a character with a parity or framing error never gives out_match. With bit 5 set, such a character is compared like a good one.
- R5: With option bit 6 set, the character after an unescaped escape character has out_escaped=1 and out_match=0. Only that one character is affected. An escaped escape character does not arm the escape again.
- R6: With option bit 6 clear, out_escaped is always 0 and escape characters have no effect on matching.
- R7: An accepted break character (in_break=1) produces one result with out_brk_start=1, out_has_char=0, out_data=0x00 and out_match=0.
- R8: With option bit 2 set when the break is accepted, the block watches for the end of the break. Further break characters are absorbed with no result. The first non-break character gives its normal result plus out_brk_end=1. An in_idle pulse instead gives a result with out_brk_end=1 and out_has_char=0.
- R9: With option bit 2 clear, no result carries out_brk_end. An in_idle pulse outside watching produces no result.
- R10: A result stays valid and unchanged until out_ack. in_ready is 0 while a result is held. A character is accepted on a cycle with in_valid and in_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Option register write strobe |
| cfg_wdata | input | 8 | Option register write data |
| cfg_rdata | output | 8 | Option register contents |
| esc_char | input | 8 | Escape character |
| match_char | input | 8 | Special match character |
| in_valid | input | 1 | Received character strobe |
| in_ready | output | 1 | Output slot free; input accepted |
| in_data | input | 8 | Received character |
| in_parity_err | input | 1 | Parity error flag |
| in_frame_err | input | 1 | Framing error flag |
| in_break | input | 1 | Character is a break (all zero with framing error) |
| in_idle | input | 1 | Idle-line indication pulse |
| out_valid | output | 1 | Result held in slot |
| out_ack | input | 1 | Consumer takes the result |
| out_data | output | 8 | Processed character |
| out_has_char | output | 1 | Result carries a data character |
| out_match | output | 1 | Special-character match |
| out_escaped | output | 1 | Character followed an escape |
| out_brk_start | output | 1 | Break start event |
| out_brk_end | output | 1 | Break end event |

## Verification
A single result can carry three outcomes at once: the end of a watched break, the ordinary match decision and the escape decision. The bench enables break tracking and sends a break followed by a second absorbed break. It then sends the match character, so that the break-end flag and the match flag must both be set in one held result. A further case sends an escape character first, so that the end-of-break result must instead show escaped with no match. A scoreboard predicts every field of each result from the requirements and compares it when the slot fills.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    parameter int CHAR_W = 8;

    localparam int OPT_STRIP  = 7;
    localparam int OPT_ESC    = 6;
    localparam int OPT_ERRCMP = 5;
    localparam int OPT_EOB    = 2;
    localparam logic [7:0] OPT_MASK = 8'hE4;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_HOLD,
        ST_WATCH,
        ST_WATCH_HOLD
    } rxf_state_e;

    typedef struct packed {
        logic strip;
        logic esc_en;
        logic err_cmp;
        logic eob_en;
    } rxf_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              has_char;
        logic              match;
        logic              escaped;
        logic              brk_start;
        logic              brk_end;
    } rxf_item_t;
endpackage

// File: rtl/rxf_opt_reg.sv
module rxf_opt_reg
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output rxf_cfg_t   cfg
);
    logic [7:0] opt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            opt_q <= 8'h00;
        else if (wr)
            opt_q <= wdata & OPT_MASK;
    end

    assign rdata       = opt_q;
    assign cfg.strip   = opt_q[OPT_STRIP];
    assign cfg.esc_en  = opt_q[OPT_ESC];
    assign cfg.err_cmp = opt_q[OPT_ERRCMP];
    assign cfg.eob_en  = opt_q[OPT_EOB];
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
(
    input  rxf_cfg_t          cfg,
    input  logic              esc_armed,
    input  logic [CHAR_W-1:0] raw,
    input  logic              perr,
    input  logic              ferr,
    input  logic [CHAR_W-1:0] esc_char,
    input  logic [CHAR_W-1:0] match_char,
    output logic [CHAR_W-1:0] chr,
    output logic              match,
    output logic              escaped,
    output logic              esc_next
);
    logic cmp_ok;

    always_comb begin
        chr = raw;
        if (cfg.strip)
            chr[CHAR_W-1] = 1'b0;
        cmp_ok   = cfg.err_cmp || !(perr || ferr);
        escaped  = cfg.esc_en && esc_armed;
        match    = cmp_ok && !escaped && (chr == match_char);
        esc_next = cfg.esc_en && !escaped && (chr == esc_char);
    end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eob_en,
    input  logic              in_valid,
    input  logic              in_break,
    input  logic              in_idle,
    input  logic              out_ack,
    input  logic [CHAR_W-1:0] chr,
    input  logic              match,
    input  logic              escaped,
    input  logic              esc_next,
    output logic              in_ready,
    output logic              esc_armed,
    output logic              out_valid,
    output rxf_item_t         item
);
    rxf_state_e state, state_nx;
    logic take, load_brk, load_chr, load_idle, watching;

    assign in_ready  = (state == ST_OPEN) || (state == ST_WATCH);
    assign out_valid = (state == ST_HOLD) || (state == ST_WATCH_HOLD);
    assign watching  = (state == ST_WATCH);
    assign take      = in_valid && in_ready;
    assign load_brk  = take && in_break && (state == ST_OPEN);
    assign load_chr  = take && !in_break;
    assign load_idle = watching && !take && in_idle;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: begin
                if (take && in_break)
                    state_nx = eob_en ? ST_WATCH_HOLD : ST_HOLD;
                else if (take)
                    state_nx = ST_HOLD;
            end
            ST_HOLD:       if (out_ack) state_nx = ST_OPEN;
            ST_WATCH: begin
                if (take && !in_break)
                    state_nx = ST_HOLD;
                else if (!take && in_idle)
                    state_nx = ST_HOLD;
            end
            ST_WATCH_HOLD: if (out_ack) state_nx = ST_WATCH;
            default:       state_nx = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OPEN;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item      <= '0;
            esc_armed <= 1'b0;
        end else if (load_brk) begin
            item           <= '0;
            item.brk_start <= 1'b1;
        end else if (load_chr) begin
            item.data      <= chr;
            item.has_char  <= 1'b1;
            item.match     <= match;
            item.escaped   <= escaped;
            item.brk_start <= 1'b0;
            item.brk_end   <= watching;
            esc_armed      <= esc_next;
        end else if (load_idle) begin
            item         <= '0;
            item.brk_end <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_char_filter.sv
module rx_char_filter
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [CHAR_W-1:0] esc_char,
    input  logic [CHAR_W-1:0] match_char,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_parity_err,
    input  logic              in_frame_err,
    input  logic              in_break,
    input  logic              in_idle,
    output logic              out_valid,
    input  logic              out_ack,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_has_char,
    output logic              out_match,
    output logic              out_escaped,
    output logic              out_brk_start,
    output logic              out_brk_end
);
    rxf_cfg_t          cfg;
    rxf_item_t         item;
    logic [CHAR_W-1:0] chr;
    logic              match, escaped, esc_next, esc_armed;

    rxf_opt_reg u_opt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    rxf_classify u_cls (
        .cfg        (cfg),
        .esc_armed  (esc_armed),
        .raw        (in_data),
        .perr       (in_parity_err),
        .ferr       (in_frame_err),
        .esc_char   (esc_char),
        .match_char (match_char),
        .chr        (chr),
        .match      (match),
        .escaped    (escaped),
        .esc_next   (esc_next)
    );

    rxf_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .eob_en    (cfg.eob_en),
        .in_valid  (in_valid),
        .in_break  (in_break),
        .in_idle   (in_idle),
        .out_ack   (out_ack),
        .chr       (chr),
        .match     (match),
        .escaped   (escaped),
        .esc_next  (esc_next),
        .in_ready  (in_ready),
        .esc_armed (esc_armed),
        .out_valid (out_valid),
        .item      (item)
    );

    assign out_data      = item.data;
    assign out_has_char  = item.has_char;
    assign out_match     = item.match;
    assign out_escaped   = item.escaped;
    assign out_brk_start = item.brk_start;
    assign out_brk_end   = item.brk_end;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_break,
    input logic       in_parity_err,
    input logic       in_frame_err,
    input logic       out_valid,
    input logic       out_ack,
    input logic [7:0] out_data,
    input logic       out_has_char,
    input logic       out_match,
    input logic       out_escaped,
    input logic       out_brk_start
);
    // R1
    opt_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4:3] == 2'b00 && cfg_rdata[1:0] == 2'b00);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_data) && $stable(out_match)
        && $stable(out_escaped) && $stable(out_brk_start));

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2
    strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_rdata[7] |=> out_data[7] == 1'b0);

    // R4
    err_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_break && (in_parity_err || in_frame_err) && !cfg_rdata[5]
        |=> !out_match);

    // R5
    esc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_escaped |-> !out_match);

    // R7
    brk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_brk_start |-> !out_has_char && !out_match && out_data == 8'h00);
endmodule

bind rx_char_filter rxf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rdata     (cfg_rdata),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_break      (in_break),
    .in_parity_err (in_parity_err),
    .in_frame_err  (in_frame_err),
    .out_valid     (out_valid),
    .out_ack       (out_ack),
    .out_data      (out_data),
    .out_has_char  (out_has_char),
    .out_match     (out_match),
    .out_escaped   (out_escaped),
    .out_brk_start (out_brk_start)
);

// File: tb/sim_rx_char_filter.sv
`timescale 1ns/1ps
module sim_rx_char_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [7:0] esc_char = 8'h1B;
    logic [7:0] match_char = 8'h41;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_parity_err = 1'b0;
    logic       in_frame_err = 1'b0;
    logic       in_break = 1'b0;
    logic       in_idle = 1'b0;
    logic       out_valid;
    logic       out_ack = 1'b0;
    logic [7:0] out_data;
    logic       out_has_char, out_match, out_escaped, out_brk_start, out_brk_end;

    always #2 clk = ~clk;

    rx_char_filter u0 (.*);

    typedef struct {
        logic [12:0] v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   ack_wait = 0;
    int   cycles = 0;
    bit   m_esc = 0;
    bit   m_watch = 0;
    logic [7:0] m_cfg = 8'h00;

    task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    function automatic logic [12:0] pack(logic [7:0] d, bit h, bit m, bit e, bit bs, bit be);
        return {d, h, m, e, bs, be};
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_cfg = v & 8'hE4;
    endtask

    // driver: predicts the result from the requirements
    task automatic send(input logic [7:0] d, input bit pe, input bit fe, input bit br, input string tag);
        logic [7:0] c;
        bit esc_now, ok, mt;
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        c = m_cfg[7] ? {1'b0, d[6:0]} : d;
        e.tag = tag;
        if (br) begin
            if (!m_watch) begin
                e.v = pack(8'h00, 0, 0, 0, 1, 0);
                q.push_back(e);
                if (m_cfg[2]) m_watch = 1;
            end
        end else begin
            esc_now = m_cfg[6] && m_esc;
            ok = m_cfg[5] || !(pe || fe);
            mt = ok && !esc_now && (c == match_char);
            e.v = pack(c, 1, mt, esc_now, 0, m_watch);
            q.push_back(e);
            m_watch = 0;
            m_esc = m_cfg[6] && !esc_now && (c == esc_char);
        end
        in_valid = 1'b1; in_data = d; in_parity_err = pe; in_frame_err = fe; in_break = br;
        @(negedge clk);
        in_valid = 1'b0; in_parity_err = 1'b0; in_frame_err = 1'b0; in_break = 1'b0;
    endtask

    task automatic idle_pulse(input string tag);
        exp_t e;
        bit was_watch;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        was_watch = m_watch;
        if (m_watch) begin
            e.tag = tag;
            e.v = pack(8'h00, 0, 0, 0, 0, 1);
            q.push_back(e);
            m_watch = 0;
        end
        in_idle = 1'b1;
        @(negedge clk);
        in_idle = 1'b0;
        if (!was_watch) begin
            @(negedge clk);
            chk(!out_valid, {tag, " idle ignored"}, {31'd0, out_valid}, 32'd0);
        end
    endtask

    task automatic drain();
        while (q.size() != 0 || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        logic [12:0] act;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                act = {out_data, out_has_char, out_match, out_escaped, out_brk_start, out_brk_end};
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected result", {19'd0, act}, 32'd0);
                end else begin
                    e = q.pop_front();
                    chk(act == e.v, e.tag, {19'd0, act}, {19'd0, e.v});
                end
                for (int i = 0; i < ack_wait; i++) begin
                    @(negedge clk);
                    chk(out_valid && !in_ready &&
                        {out_data, out_has_char, out_match, out_escaped, out_brk_start, out_brk_end} == act,
                        "R10 held until ack", {19'd0, out_data, out_has_char, out_match, out_escaped,
                        out_brk_start, out_brk_end}, {19'd0, act});
                end
                out_ack = 1'b1;
                @(negedge clk);
                out_ack = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 reset value", {24'd0, cfg_rdata}, 32'h00);
        chk(in_ready && !out_valid, "R10 reset slot free", {30'd0, in_ready, out_valid}, 32'h2);
        write_cfg(8'hFF);
        chk(cfg_rdata == 8'hE4, "R1 masked write", {24'd0, cfg_rdata}, 32'hE4);
        write_cfg(8'h18);
        chk(cfg_rdata == 8'h00, "R1 bits 4:3 hold 0", {24'd0, cfg_rdata}, 32'h00);

        // R3 plain matching
        send(8'h41, 0, 0, 0, "R3 match");
        send(8'h42, 0, 0, 0, "R3 no match");
        send(8'hC1, 0, 0, 0, "R3 bit7 kept no match");
        // R2 strip
        write_cfg(8'h80);
        send(8'hC1, 0, 0, 0, "R2 strip then match");
        send(8'hFF, 0, 0, 0, "R2 strip data");
        // R4 errors
        send(8'h41, 1, 0, 0, "R4 parity err no match");
        send(8'h41, 0, 1, 0, "R4 frame err no match");
        write_cfg(8'hA0);
        send(8'hC1, 0, 1, 0, "R4 compare on error");
        // R5 escape
        write_cfg(8'h40);
        send(8'h1B, 0, 0, 0, "R5 escape char");
        send(8'h41, 0, 0, 0, "R5 escaped no match");
        send(8'h41, 0, 0, 0, "R5 escape cleared");
        send(8'h1B, 0, 0, 0, "R5 escape arm");
        send(8'h1B, 0, 0, 0, "R5 escaped escape");
        send(8'h41, 0, 0, 0, "R5 not rearmed");
        // R6 escape disabled
        write_cfg(8'h00);
        send(8'h1B, 0, 0, 0, "R6 esc char plain");
        send(8'h41, 0, 0, 0, "R6 no escape effect");
        // R7 / R9 break without end tracking
        send(8'h00, 0, 1, 1, "R7 break start");
        idle_pulse("R9");
        send(8'h41, 0, 0, 0, "R9 no break end");
        // R8 end of break: coincident with match
        write_cfg(8'h04);
        send(8'h00, 0, 1, 1, "R8 break start tracked");
        send(8'h00, 0, 1, 1, "R8 absorbed break");
        send(8'h41, 0, 0, 0, "R8 end with match");
        send(8'h00, 0, 1, 1, "R8 break again");
        idle_pulse("R8 end by idle");
        // R8 coincident with escape
        write_cfg(8'h44);
        send(8'h1B, 0, 0, 0, "R8 escape before break");
        send(8'h00, 0, 1, 1, "R8 break keeps escape");
        send(8'h41, 0, 0, 0, "R8 end with escaped");
        drain();
        // R10 delayed acknowledge
        ack_wait = 4;
        write_cfg(8'h00);
        send(8'h41, 0, 0, 0, "R10 slow ack a");
        send(8'h43, 0, 0, 0, "R10 slow ack b");
        drain();
        chk(q.size() == 0, "R10 scoreboard empty", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule